// File: doc/BRIEF.md
# Sixteen-bit Timer with Clear-on-Match and Input Capture

This block is a synchronous 16-bit up-counter. It advances only on cycles where an external prescaler raises a one-cycle tick enable. A mode bit selects one of two behaviours.

In free-running mode the counter counts up and rolls over. An edge on an external capture pin, synchronised and edge-selected, copies the running count into a shared period/capture register. In clear-on-match mode that same register acts as the period limit. The counter returns to zero on the tick after it equals the limit. Limit writes are not double-buffered. A limit written below the running count is therefore missed, and the counter runs on through 0xFFFF before it matches.

Software reaches the counter, the period/capture register, a control register and a flag register through a simple word-wide register port. Reads are registered. Two interrupt outputs report the overflow flag and the match/capture flag, each gated by its own enable bit.

Top module: `ctc_timer16`

## Requirements
- R1: The count changes only on a cycle with `tick` high or with a bus write to the count register. On every other cycle it holds its value.
- R2: In free-running mode (control bit 0 = 0) each tick adds one to the count. A tick at 0xFFFF gives 0x0000 and sets the overflow flag (flag bit 0) at the same clock edge. A count equal to the period register is not cleared in this mode.
- R3: In clear-on-match mode (control bit 0 = 1), a tick while the count equals the period register loads zero and sets the match/capture flag (flag bit 1) at the same edge. A tick at 0xFFFF also sets the overflow flag, including the case where the period is 0xFFFF.
- R4: A write to the period register takes effect from the next cycle. If the new period is below the running count, no match occurs until the count has rolled over from 0xFFFF to 0x0000, which sets the overflow flag, and counted back up.
- R5: A period of zero in clear-on-match mode holds the count at zero and sets the match/capture flag on every tick.
- R6: A bus write to the count register in the same cycle as a tick loads the written value, and that cycle's increment is dropped.
- R7: In free-running mode a capture-pin edge copies the count into the period/capture register and sets flag bit 1. Control bit 1 = 1 selects rising edges and 0 selects falling edges, and the other edge is ignored. After two synchroniser flops, the copy happens at the third rising clock edge after the pin changes.
- R8: In clear-on-match mode capture-pin edges are ignored. Neither the period/capture register nor flag bit 1 changes.
- R9: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R10: `irq_ovf` equals flag bit 0 AND control bit 2. `irq_top` equals flag bit 1 AND control bit 3. Both change at the same edge as the flag.
- R11: Register map by `bus_addr`: 0 is the count, 1 is period/capture, 2 is control (bits 3..0 as above, upper bits read 0), and 3 is flags (bits 1..0, upper bits read 0). `bus_rdata` shows the addressed register one clock after the address is presented. Reset clears every register and both interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable from the prescaler, one cycle per timer step |
| cap_in | input | 1 | Asynchronous capture event pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Registered read data for the addressed register |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_top | output | 1 | Match/capture interrupt request |

## Verification
Eight vectors drive the count with different start values, periods, modes and tick counts. Together they separate a plain increment, a rollover, a clear at the period, a period lying below the start count that forces a full wrap, a zero period, and a period of 0xFFFF where both flags fire on one tick. Directed tests then cover the idle hold, a count write that collides with a tick, and flag clearing with mixed one/zero patterns. Capture is exercised on both edge polarities with the opposite edge present. Its latency is checked cycle by cycle, and it is shown to be ignored in clear-on-match mode.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

  localparam int ADDR_W  = 2;
  localparam int CTRL_W  = 4;
  localparam int FLAG_W  = 2;
  localparam int FLG_OVF = 0;
  localparam int FLG_TOP = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT  = 2'd0,
    REG_TOPCAP = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAGS  = 2'd3
  } reg_addr_e;

  // bit0 clr_mode, bit1 edge_rise, bit2 ovf_ie, bit3 top_ie
  typedef struct packed {
    logic top_ie;
    logic ovf_ie;
    logic edge_rise;
    logic clr_mode;
  } ctrl_t;

endpackage

// File: rtl/ctc_capsync.sv
module ctc_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_in,
  input  logic edge_rise,
  output logic edge_hit
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= cap_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], cap_in};
      end
    end
  endgenerate

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= cur;
  end

  // one-cycle pulse; consumer registers it on the following edge
  assign edge_hit = edge_rise ? (cur & ~prev_q) : (~cur & prev_q);

endmodule

// File: rtl/ctc_counter.sv
module ctc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr_mode,
  input  logic [W-1:0] top,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         ovf_evt,
  output logic         top_evt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic step;

  // a software write in the same cycle suppresses the tick
  assign step    = tick & ~wr_en;
  assign top_evt = step & clr_mode & (count == top);
  assign ovf_evt = step & (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (wr_en)   count <= wr_data;
    else if (top_evt) count <= '0;
    else if (step)    count <= count + 1'b1;
  end

endmodule

// File: rtl/ctc_regs.sv
module ctc_regs
  import ctc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      count,
  input  logic              ovf_evt,
  input  logic              top_evt,
  input  logic              cap_evt,
  output logic              cnt_wr,
  output logic [W-1:0]      topcap,
  output ctrl_t             ctrl,
  output logic [FLAG_W-1:0] flags,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_ovf,
  output logic              irq_top
);

  logic              wr_top, wr_ctl, wr_flg;
  logic              cap_take;
  logic [FLAG_W-1:0] flag_set, flag_clr, flags_d;
  ctrl_t             ctrl_d;

  assign cnt_wr = bus_we && (bus_addr == REG_COUNT);
  assign wr_top = bus_we && (bus_addr == REG_TOPCAP);
  assign wr_ctl = bus_we && (bus_addr == REG_CTRL);
  assign wr_flg = bus_we && (bus_addr == REG_FLAGS);

  assign cap_take = cap_evt & ~ctrl.clr_mode;

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_OVF] = ovf_evt;
    flag_set[FLG_TOP] = top_evt | cap_take;
    flag_clr          = wr_flg ? bus_wdata[FLAG_W-1:0] : '0;
    flags_d           = (flags & ~flag_clr) | flag_set;
    ctrl_d            = wr_ctl ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      topcap  <= '0;
      ctrl    <= '0;
      flags   <= '0;
      irq_ovf <= 1'b0;
      irq_top <= 1'b0;
    end else begin
      if (wr_top)        topcap <= bus_wdata;
      else if (cap_take) topcap <= count;
      ctrl    <= ctrl_d;
      flags   <= flags_d;
      irq_ovf <= flags_d[FLG_OVF] & ctrl_d.ovf_ie;
      irq_top <= flags_d[FLG_TOP] & ctrl_d.top_ie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (reg_addr_e'(bus_addr))
        REG_COUNT:  bus_rdata <= count;
        REG_TOPCAP: bus_rdata <= topcap;
        REG_CTRL:   bus_rdata <= {{(W-CTRL_W){1'b0}}, ctrl};
        default:    bus_rdata <= {{(W-FLAG_W){1'b0}}, flags};
      endcase
    end
  end

endmodule

// File: rtl/ctc_timer16.sv
module ctc_timer16
  import ctc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cap_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_ovf,
  output logic              irq_top
);

  logic [CNT_W-1:0]  count_w, topcap_w;
  logic              ovf_evt_w, top_evt_w, cap_evt_w, cnt_wr_w;
  logic              clr_mode_w;
  logic [FLAG_W-1:0] flags_w;
  ctrl_t             ctrl_w;

  assign clr_mode_w = ctrl_w.clr_mode;

  ctc_capsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .cap_in    (cap_in),
    .edge_rise (ctrl_w.edge_rise),
    .edge_hit  (cap_evt_w)
  );

  ctc_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .clr_mode (clr_mode_w),
    .top      (topcap_w),
    .wr_en    (cnt_wr_w),
    .wr_data  (bus_wdata),
    .count    (count_w),
    .ovf_evt  (ovf_evt_w),
    .top_evt  (top_evt_w)
  );

  ctc_regs #(.W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count     (count_w),
    .ovf_evt   (ovf_evt_w),
    .top_evt   (top_evt_w),
    .cap_evt   (cap_evt_w),
    .cnt_wr    (cnt_wr_w),
    .topcap    (topcap_w),
    .ctrl      (ctrl_w),
    .flags     (flags_w),
    .bus_rdata (bus_rdata),
    .irq_ovf   (irq_ovf),
    .irq_top   (irq_top)
  );

endmodule

// File: rtl/ctc_timer16_chk.sv
module ctc_timer16_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         cnt_wr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] count,
  input logic [W-1:0] top,
  input logic         clr_mode,
  input logic [1:0]   flags,
  input logic         irq_ovf,
  input logic         irq_top
);

  logic [W-1:0] count_inc;
  assign count_inc = count + 1'b1;

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(count));

  assert_free_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr_mode && tick && !cnt_wr) |=> (count == $past(count_inc)));

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr && (&count)) |=> flags[0]);

  assert_match_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_mode && tick && !cnt_wr && (count == top)) |=> ((count == '0) && flags[1]));

  assert_write_wins_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count == $past(wdata)));

  assert_irq_ovf_R10: assert property (@(posedge clk) disable iff (rst)
    irq_ovf |-> flags[0]);

  assert_irq_top_R10: assert property (@(posedge clk) disable iff (rst)
    irq_top |-> flags[1]);

endmodule

bind ctc_timer16 ctc_timer16_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .cnt_wr   (cnt_wr_w),
  .wdata    (bus_wdata),
  .count    (count_w),
  .top      (topcap_w),
  .clr_mode (clr_mode_w),
  .flags    (flags_w),
  .irq_ovf  (irq_ovf),
  .irq_top  (irq_top)
);

// File: tb/test_ctc_timer16.sv
`timescale 1ns/1ps
module test_ctc_timer16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        cap_in = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq_ovf, irq_top;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ctc_timer16 i_ctc_timer16 (
    .clk(clk), .rst(rst), .tick(tick), .cap_in(cap_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ovf(irq_ovf), .irq_top(irq_top)
  );

  typedef struct packed {
    logic        mode;
    logic [15:0] start;
    logic [15:0] top;
    logic [7:0]  nticks;
    logic [15:0] exp_cnt;
    logic [1:0]  exp_flg;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{1'b0, 16'h0010, 16'h0000, 8'd5,  16'h0015, 2'b00},  // R2 plain count
    '{1'b0, 16'hFFFE, 16'h0000, 8'd3,  16'h0001, 2'b01},  // R2 rollover
    '{1'b1, 16'h0000, 16'h0007, 8'd10, 16'h0002, 2'b10},  // R3 clear at period
    '{1'b1, 16'h0020, 16'h0005, 8'd10, 16'h002A, 2'b00},  // R4 period below count
    '{1'b1, 16'hFFFD, 16'h0005, 8'd4,  16'h0001, 2'b01},  // R4 wrap before match
    '{1'b1, 16'h0000, 16'h0000, 8'd3,  16'h0000, 2'b10},  // R5 zero period
    '{1'b0, 16'h0000, 16'h0003, 8'd6,  16'h0006, 2'b00},  // R2 no clear in free mode
    '{1'b1, 16'hFFFE, 16'hFFFF, 8'd2,  16'h0000, 2'b11}   // R3 both flags
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] old;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(a[1:0], rd);
      check("R11 reset reg", rd, 16'h0000);
    end
    check("R11 reset irq", {14'h0, irq_top, irq_ovf}, 16'h0000);

    // vector table
    for (int i = 0; i < 8; i++) begin
      bus_write(2'd2, {15'h0, VEC[i].mode});
      bus_write(2'd1, VEC[i].top);
      bus_write(2'd0, VEC[i].start);
      bus_write(2'd3, 16'h0003);
      run_ticks(int'(VEC[i].nticks));
      bus_read(2'd0, rd);
      check($sformatf("R2/R3/R4/R5 vec%0d count", i), rd, VEC[i].exp_cnt);
      bus_read(2'd3, rd);
      check($sformatf("R2/R3/R4/R5 vec%0d flags", i), rd, {14'h0, VEC[i].exp_flg});
    end

    // R9 flags at 3 after the last vector
    bus_write(2'd3, 16'h0000);
    bus_read(2'd3, rd);
    check("R9 zero write keeps flags", rd, 16'h0003);
    bus_write(2'd3, 16'h0001);
    bus_read(2'd3, rd);
    check("R9 clear overflow only", rd, 16'h0002);
    bus_write(2'd3, 16'h0002);
    bus_read(2'd3, rd);
    check("R9 clear match flag", rd, 16'h0000);

    // R11 control readback
    bus_write(2'd2, 16'hFFF6);
    bus_read(2'd2, rd);
    check("R11 ctrl readback", rd, 16'h0006);

    // R1 idle hold
    bus_write(2'd2, 16'h0000);
    bus_write(2'd0, 16'h0777);
    wait_cycles(6);
    bus_read(2'd0, rd);
    check("R1 idle hold", rd, 16'h0777);

    // R6 write beats tick
    @(negedge clk);
    tick = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h0100;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    bus_read(2'd0, rd);
    check("R6 write priority", rd, 16'h0100);

    // R10 overflow interrupt
    bus_write(2'd2, 16'h0004);
    bus_write(2'd3, 16'h0003);
    bus_write(2'd0, 16'hFFFF);
    run_ticks(1);
    check("R10 irq_ovf set", {15'h0, irq_ovf}, 16'h0001);
    check("R10 irq_top idle", {15'h0, irq_top}, 16'h0000);
    bus_write(2'd3, 16'h0001);
    check("R10 irq_ovf cleared", {15'h0, irq_ovf}, 16'h0000);

    // R10 match interrupt
    bus_write(2'd2, 16'h0009);
    bus_write(2'd1, 16'h0002);
    bus_write(2'd0, 16'h0002);
    run_ticks(1);
    check("R10 irq_top set", {15'h0, irq_top}, 16'h0001);
    check("R10 irq_ovf masked", {15'h0, irq_ovf}, 16'h0000);

    // R7 rising capture with latency
    bus_write(2'd2, 16'h0002);
    bus_write(2'd3, 16'h0003);
    bus_write(2'd0, 16'h1234);
    bus_read(2'd1, old);
    @(negedge clk);
    cap_in = 1'b1;
    wait_cycles(3);
    check("R7 no capture before third edge", bus_rdata, old);
    wait_cycles(1);
    check("R7 capture on third edge", bus_rdata, 16'h1234);
    bus_read(2'd3, rd);
    check("R7 capture flag", rd, 16'h0002);

    // R7 falling edge ignored when rising selected
    bus_write(2'd0, 16'h5555);
    @(negedge clk);
    cap_in = 1'b0;
    wait_cycles(5);
    bus_read(2'd1, rd);
    check("R7 opposite edge ignored", rd, 16'h1234);

    // R7 falling edge selected
    bus_write(2'd2, 16'h0000);
    @(negedge clk);
    cap_in = 1'b1;
    wait_cycles(5);
    bus_read(2'd1, rd);
    check("R7 rising ignored in falling select", rd, 16'h1234);
    bus_write(2'd0, 16'h0ABC);
    @(negedge clk);
    cap_in = 1'b0;
    wait_cycles(5);
    bus_read(2'd1, rd);
    check("R7 falling capture", rd, 16'h0ABC);

    // R8 capture ignored in clear-on-match mode
    bus_write(2'd2, 16'h0003);
    bus_write(2'd1, 16'h0040);
    bus_write(2'd0, 16'h0000);
    bus_write(2'd3, 16'h0003);
    @(negedge clk);
    cap_in = 1'b1;
    wait_cycles(5);
    bus_read(2'd1, rd);
    check("R8 period kept", rd, 16'h0040);
    bus_read(2'd3, rd);
    check("R8 no capture flag", rd, 16'h0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule